// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register Bank

This block is the software-visible control register file of an audio codec. It answers a simple word-addressed bus inside a 64-byte window. The window holds sixteen 32-bit direct words. One of those words is a data port into a second bank of thirty-two 8-bit indirect registers. The low five bits of direct word 0 select which indirect register the port reaches.

Several locations follow special rules. One indirect slot can be written but always reads back as zero. Two indirect slots are read-only, and one of them carries a fixed identity code. Another indirect slot stores a single writable bit merged with a fixed code. Direct word 2 cannot be written. Direct word 4 is a control word: writing it with bit 0 set returns every register to its reset value, and the word then keeps the written value masked to seven bits. The interrupt output is present but stays inactive.

Every bus strobe is sorted into one access kind by a decoder. The kinds are: none, read, plain write, data-port write, control write, soft reset and dropped write. Read data is registered and appears on the cycle after the read strobe.

Top module: `codec_regbank`

## Requirements
- R1: After the asynchronous reset (rst_n low), every direct word and every indirect register reads as zero, with two exceptions. Indirect index 12 reads 0x8A and indirect index 25 reads 0xA0. bus_rdata is also zero.
- R2: The direct word is selected by bus_addr[5:2], and bus_addr[1:0] are ignored. Any direct word other than 1, 2 and 4 stores all 32 written bits and returns them on a read.
- R3: Indirect access goes through direct word 1. The indirect index is bits 4:0 of direct word 0, and its upper bits are ignored. Reads through word 1 return the selected 8-bit register zero-extended to 32 bits. Writes through word 1 use only bus_wdata[7:0].
- R4: Indirect index 3 accepts writes, but a read of it through word 1 always returns 0.
- R5: Writes through word 1 to indirect indices 11 and 25 leave those registers unchanged.
- R6: A write through word 1 to indirect index 12 stores (bus_wdata & 0x40) | 0x8A.
- R7: Direct word 2 ignores writes and always reads 0.
- R8: A write to direct word 4 with bus_wdata[0]=1 returns all registers to their R1 values. In the same cycle, word 4 takes bus_wdata & 0x7F.
- R9: A write to direct word 4 with bus_wdata[0]=0 stores bus_wdata & 0x7F and leaves every other register unchanged.
- R10: irq is low at all times.
- R11: bus_rdata changes only on the clock edge that samples a read strobe (bus_valid=1, bus_write=0). It holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read (qualified by bus_valid) |
| bus_addr | input | 6 | Byte address within the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt request, held low |

## Verification
A write takes effect on the edge that samples its strobe. A read issued in the next cycle therefore already sees the new value, and its data lands on bus_rdata one edge after that read strobe. The soft reset follows the same pattern: every register holds its reset value from the edge of the control write, and the control word holds its masked value from that same edge. The bench changes inputs and samples bus_rdata on falling edges only, so each check reads the value produced by the rising edge just before it. The hold checks sample bus_rdata after write and idle cycles to show that it has not moved.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;

    // Kind of bus access seen in one cycle
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WR_PLAIN,
        ACC_WR_PORT,
        ACC_WR_CTRL,
        ACC_SOFT_RST,
        ACC_WR_DROP
    } acc_kind_t;

    // Per-slot behaviour of the indirect bank
    typedef enum logic [1:0] {
        SLOT_PLAIN,
        SLOT_RO,
        SLOT_MIX
    } slot_rule_t;

    // Direct word roles
    localparam int PORT_WORD   = 1;
    localparam int STATUS_WORD = 2;
    localparam int CTRL_WORD   = 4;

    // Indirect slot roles
    localparam int WO_SLOT   = 3;
    localparam int RO_SLOT_A = 11;
    localparam int MIX_SLOT  = 12;
    localparam int RO_SLOT_B = 25;

    localparam logic [7:0]  MIX_CODE  = 8'h8A;
    localparam logic [7:0]  MIX_KEEP  = 8'h40;
    localparam logic [7:0]  ID_CODE   = 8'hA0;
    localparam logic [31:0] CTRL_KEEP = 32'h0000_007F;

    function automatic slot_rule_t rule_of(input int idx);
        case (idx)
            RO_SLOT_A, RO_SLOT_B: return SLOT_RO;
            MIX_SLOT:             return SLOT_MIX;
            default:              return SLOT_PLAIN;
        endcase
    endfunction

    function automatic logic [7:0] reset_of(input int idx);
        case (idx)
            MIX_SLOT:  return MIX_CODE;
            RO_SLOT_B: return ID_CODE;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/codec_access_decode.sv
module codec_access_decode
    import codec_regbank_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int WIDX_W = ADDR_W - 2
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wdata_lsb,
    output acc_kind_t         kind,
    output logic [WIDX_W-1:0] widx
);

    logic unused_byte_lanes;
    assign unused_byte_lanes = ^bus_addr[1:0];

    always_comb begin
        widx = bus_addr[ADDR_W-1:2];
        kind = ACC_NONE;
        unique case ({bus_valid, bus_write})
            2'b10: kind = ACC_READ;
            2'b11: begin
                if (widx == WIDX_W'(PORT_WORD))
                    kind = ACC_WR_PORT;
                else if (widx == WIDX_W'(STATUS_WORD))
                    kind = ACC_WR_DROP;
                else if (widx == WIDX_W'(CTRL_WORD))
                    kind = wdata_lsb ? ACC_SOFT_RST : ACC_WR_CTRL;
                else
                    kind = ACC_WR_PLAIN;
            end
            default: kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
    import codec_regbank_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    parameter int DATA_W    = 32,
    localparam int WIDX_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         kind,
    input  logic [WIDX_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] words [NUM_WORDS]
);

    localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == PORT_WORD || i == STATUS_WORD) begin : g_none
            assign words[i] = '0;
        end else if (i == CTRL_WORD) begin : g_ctrl
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (kind == ACC_SOFT_RST || kind == ACC_WR_CTRL)
                    q <= wdata & KEEP;
            end
            assign words[i] = q;
        end else begin : g_plain
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (kind == ACC_SOFT_RST)
                    q <= '0;
                else if (kind == ACC_WR_PLAIN && widx == WIDX_W'(i))
                    q <= wdata;
            end
            assign words[i] = q;
        end
    end

    // R8: soft reset clears the index word on the next edge
    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_SOFT_RST) |=> (words[0] == '0));

    // R9: control word never holds bits above bit 6 after a control write
    p_ctrl_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR_CTRL) |=> (words[CTRL_WORD][DATA_W-1:7] == '0));

endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
    import codec_regbank_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 8,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_val
);

    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam slot_rule_t       RULE = rule_of(i);
        localparam logic [REG_W-1:0] RSTV = REG_W'(reset_of(i));
        if (RULE == SLOT_RO) begin : g_ro
            assign regs[i] = RSTV;
        end else begin : g_rw
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= RSTV;
                else if (soft_rst)
                    q <= RSTV;
                else if (wr_en && idx == IDX_W'(i)) begin
                    if (RULE == SLOT_MIX)
                        q <= (wdata & REG_W'(MIX_KEEP)) | REG_W'(MIX_CODE);
                    else
                        q <= wdata;
                end
            end
            assign regs[i] = q;
        end
    end

    always_comb begin
        if (idx == IDX_W'(WO_SLOT))
            rd_val = '0;
        else
            rd_val = regs[idx];
    end

    // R6: merged slot takes the kept bit plus the fixed code
    p_mix_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst && idx == IDX_W'(MIX_SLOT)) |=>
        (regs[MIX_SLOT] == (($past(wdata) & REG_W'(MIX_KEEP)) | REG_W'(MIX_CODE))));

    // R1/R8: a soft reset leaves the identity slot at its code
    p_id_after_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs[RO_SLOT_B] == REG_W'(ID_CODE)));

endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import codec_regbank_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int IND_REGS = 32,
    parameter int IND_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int WIDX_W    = ADDR_W - 2;
    localparam int NUM_WORDS = 2 ** WIDX_W;
    localparam int IDX_W     = $clog2(IND_REGS);

    acc_kind_t         kind;
    logic [WIDX_W-1:0] widx;
    logic [DATA_W-1:0] words [NUM_WORDS];
    logic [IDX_W-1:0]  ind_idx;
    logic [IND_W-1:0]  ind_rd;
    logic [DATA_W-1:0] rd_next;

    codec_access_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wdata_lsb (bus_wdata[0]),
        .kind      (kind),
        .widx      (widx)
    );

    codec_direct_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_direct (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .widx  (widx),
        .wdata (bus_wdata),
        .words (words)
    );

    assign ind_idx = words[0][IDX_W-1:0];

    codec_indirect_bank #(.NUM_REGS(IND_REGS), .REG_W(IND_W)) u_indirect (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (kind == ACC_SOFT_RST),
        .wr_en    (kind == ACC_WR_PORT),
        .idx      (ind_idx),
        .wdata    (bus_wdata[IND_W-1:0]),
        .rd_val   (ind_rd)
    );

    always_comb begin
        if (widx == WIDX_W'(PORT_WORD))
            rd_next = {{(DATA_W-IND_W){1'b0}}, ind_rd};
        else
            rd_next = words[widx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (kind == ACC_READ)
            bus_rdata <= rd_next;
    end

    assign irq = 1'b0;

    // R4: write-only slot reads back as zero
    p_wo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == WIDX_W'(PORT_WORD) && ind_idx == IDX_W'(WO_SLOT))
        |=> (bus_rdata == '0));

    // R7: status word reads as zero
    p_status_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == WIDX_W'(STATUS_WORD)) |=> (bus_rdata == '0));

    // R3: data port reads are zero-extended
    p_port_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && widx == WIDX_W'(PORT_WORD))
        |=> (bus_rdata[DATA_W-1:IND_W] == '0));

    // R11: read data holds without a read strobe
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

// File: tb/tb_codec_regbank.sv
`timescale 1ns/1ps
module tb_codec_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    codec_regbank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'h00, 32'h0,          32'h0,          4'd1}, // R1 index word
        '{1'b0, 6'h04, 32'h0,          32'h0,          4'd1}, // R1 slot 0
        '{1'b0, 6'h08, 32'h0,          32'h0,          4'd1}, // R1 status word
        '{1'b1, 6'h00, 32'h0000_000C,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_008A,  4'd1}, // R1 slot 12 code
        '{1'b1, 6'h04, 32'h0000_00FF,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_00CA,  4'd6}, // R6 kept bit set
        '{1'b1, 6'h04, 32'h0000_0035,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_008A,  4'd6}, // R6 kept bit clear
        '{1'b1, 6'h00, 32'h0000_0019,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_00A0,  4'd1}, // R1 slot 25 code
        '{1'b1, 6'h04, 32'h0000_0055,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_00A0,  4'd5}, // R5 slot 25
        '{1'b1, 6'h00, 32'h0000_000B,  32'h0,          4'd0},
        '{1'b1, 6'h04, 32'h0000_0077,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0,          4'd5}, // R5 slot 11
        '{1'b1, 6'h00, 32'hFFFF_FFE3,  32'h0,          4'd0},
        '{1'b1, 6'h04, 32'h0000_005A,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0,          4'd4}, // R4 slot 3
        '{1'b0, 6'h00, 32'h0,          32'hFFFF_FFE3,  4'd2}, // R2 word 0 full
        '{1'b1, 6'h00, 32'h0000_0007,  32'h0,          4'd0},
        '{1'b1, 6'h04, 32'h1234_56C3,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_00C3,  4'd3}, // R3 low byte only
        '{1'b1, 6'h00, 32'h0000_0027,  32'h0,          4'd0},
        '{1'b0, 6'h04, 32'h0,          32'h0000_00C3,  4'd3}, // R3 index low 5 bits
        '{1'b1, 6'h08, 32'hDEAD_BEEF,  32'h0,          4'd0},
        '{1'b0, 6'h08, 32'h0,          32'h0,          4'd7}, // R7
        '{1'b1, 6'h3C, 32'hA5A5_5A5A,  32'h0,          4'd0},
        '{1'b0, 6'h3C, 32'h0,          32'hA5A5_5A5A,  4'd2}, // R2 word 15
        '{1'b1, 6'h0C, 32'h0123_4567,  32'h0,          4'd0},
        '{1'b0, 6'h0E, 32'h0,          32'h0123_4567,  4'd2}, // R2 byte lanes ignored
        '{1'b1, 6'h10, 32'h0000_00FE,  32'h0,          4'd0},
        '{1'b0, 6'h10, 32'h0,          32'h0000_007E,  4'd9}, // R9 mask
        '{1'b0, 6'h3C, 32'h0,          32'hA5A5_5A5A,  4'd9}  // R9 no reset
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R10 irq after reset", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_write(VECS[i].addr, VECS[i].data);
            end else begin
                do_read(VECS[i].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            end
        end
        check("R10 irq after table", {31'h0, irq}, 32'h0);

        // R11: hold through writes and idle
        do_read(6'h3C, rd);
        do_write(6'h20, 32'h0000_0011);
        check("R11 hold after write", bus_rdata, 32'hA5A5_5A5A);
        repeat (3) @(negedge clk);
        check("R11 hold after idle", bus_rdata, 32'hA5A5_5A5A);

        // R8: soft reset
        do_write(6'h00, 32'h0000_000C);
        do_write(6'h04, 32'h0000_00FF);
        do_write(6'h00, 32'h0000_0000);
        do_write(6'h04, 32'h0000_0033);
        do_read(6'h04, rd);
        check("R3 slot 0 before soft reset", rd, 32'h0000_0033);
        do_write(6'h10, 32'hFFFF_FF81);
        do_read(6'h10, rd);
        check("R8 control keeps masked value", rd, 32'h0000_0001);
        do_read(6'h00, rd);
        check("R8 index word cleared", rd, 32'h0);
        do_read(6'h04, rd);
        check("R8 slot 0 cleared", rd, 32'h0);
        do_read(6'h3C, rd);
        check("R8 word 15 cleared", rd, 32'h0);
        do_read(6'h0C, rd);
        check("R8 word 3 cleared", rd, 32'h0);
        do_write(6'h00, 32'h0000_000C);
        do_read(6'h04, rd);
        check("R8 slot 12 back to code", rd, 32'h0000_008A);
        do_write(6'h00, 32'h0000_0019);
        do_read(6'h04, rd);
        check("R8 slot 25 code", rd, 32'h0000_00A0);
        check("R10 irq after soft reset", {31'h0, irq}, 32'h0);

        // R1: asynchronous reset mid-run
        do_write(6'h3C, 32'h0000_0005);
        do_read(6'h3C, rd);
        check("R2 word 15 before reset", rd, 32'h0000_0005);
        #1 rst_n = 1'b0;
        #1 check("R1 rdata cleared by reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(6'h3C, rd);
        check("R1 word 15 after reset", rd, 32'h0);
        do_read(6'h10, rd);
        check("R1 control after reset", rd, 32'h0);
        do_write(6'h00, 32'h0000_000C);
        do_read(6'h04, rd);
        check("R1 slot 12 after reset", rd, 32'h0000_008A);

        finish_run();
    end

endmodule